// File: doc/BRIEF.md
# Speculative Grandparent Wakeup Scheduler

This block is a reservation-station scheduler in which wakeup and select sit in separate pipeline stages, yet a dependent instruction can still be selected in the cycle after its producer. Each entry holds a destination tag, one tag per source operand (the parent), and for each parent the tags of that parent's own sources (the grandparents). Producers broadcast their destination tag together with a broadcast-to-result latency when they begin execution. Each operand keeps a sticky match bit and a latency countdown, and is marked ready when that countdown expires.

An entry requests selection speculatively once every grandparent of each of its parents has been broadcast. The assumption is that each parent will then be selected and broadcast in the following cycle. A parent flagged as multi-cycle is left out of this speculation, so that operand waits for its own ready bit. A separate confirm flag marks the grants whose parents are all truly ready. A grant without confirm is a false selection: the entry stays in the station and requests again. Up to `ISSUE_W` entries are granted per cycle, oldest first, and an entry is released only by a confirmed grant.

Top module: `sgw_sched`

## Requirements
- R1: Directly after reset, every issue slot is invalid and `disp_ready` is high.
- R2: An entry dispatched with no valid sources appears on the issue outputs one clock edge after the edge that accepts it. It appears once, with confirm high and its destination tag.
- R3: A source whose producer tag is sampled on a broadcast bus with latency L becomes ready max(L,1) edges later. If the entry waits only on that source, its confirmed issue appears on the outputs max(L,1) edges after the edge that sampled the broadcast. A latency of 0 behaves as 1.
- R4: The match on a source is sticky: one broadcast of its tag is enough. A broadcast of any other tag has no effect on the entry.
- R5: For a source not flagged multi-cycle, the entry is selected one edge after the edge that samples the last of that source's valid grandparent tags. Until the parent itself is ready, it is selected with confirm low. Broadcasts of only some of the grandparents do not select it.
- R6: A falsely selected entry stays in the station and is selected again in each following cycle while its request holds. It leaves only with a confirmed issue.
- R7: A source flagged multi-cycle ignores grandparent broadcasts. Its entry is not selected until that source is truly ready.
- R8: Confirm is high on a slot only when every source of the selected entry is ready. A broadcast on any of the `BC_N` buses counts.
- R9: At most `ISSUE_W` entries issue per cycle, chosen by dispatch age with the oldest first, regardless of entry position. Slot s carries the s-th oldest of the selected entries, lower slots fill first, and slot s's tag is at bits `[s*TAG_W +: TAG_W]`.
- R10: `disp_ready` is low while all `N_ENT` entries are occupied. A dispatch offered then is dropped. A confirmed issue frees its entry at the same edge.
- R11: A broadcast sampled at the same edge as the dispatch of a consumer waiting on that tag is captured by the new entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request for one instruction |
| disp_dst | input | TAG_W | Destination tag of the dispatched instruction |
| disp_src_vld | input | SRC_N | Per source: source has a producer to wait for |
| disp_src_tag | input | SRC_N*TAG_W | Per source: parent tag |
| disp_src_multi | input | SRC_N | Per source: parent is multi-cycle (no grandparent speculation) |
| disp_gp_vld | input | SRC_N*GP_N | Per source and grandparent: grandparent tag is valid |
| disp_gp_tag | input | SRC_N*GP_N*TAG_W | Per source and grandparent: grandparent tag |
| bc_valid | input | BC_N | Broadcast bus valid |
| bc_tag | input | BC_N*TAG_W | Broadcast tag per bus |
| bc_lat | input | BC_N*LAT_W | Broadcast-to-result latency per bus |
| disp_ready | output | 1 | A free entry exists |
| iss_valid | output | ISSUE_W | Issue slot holds a selected entry |
| iss_confirm | output | ISSUE_W | Selected entry has all sources truly ready |
| iss_tag | output | ISSUE_W*TAG_W | Destination tag of the selected entry per slot |

## Verification
A sweep over every broadcast latency from 0 to 7 pins the exact issue edge of the countdown, including the degenerate zero latency. Grandparent broadcasts are applied one at a time, then to all grandparents, then against a multi-cycle parent. This separates partial wakeup, speculative selection and the exclusion of the speculation. Mixed cases combine a speculatively woken source with a truly ready one, send two buses in one cycle, and place a broadcast in the dispatch cycle. These probe confirm generation and capture at load. A refill pattern places a young instruction in a low-numbered freed entry, which tells oldest-first from index priority, and filling all entries exercises the full-station drop.

// File: rtl/sgw_pkg.sv
package sgw_pkg;

    localparam int TAG_W = 6;
    localparam int LAT_W = 3;
    localparam int GP_N  = 2;

    typedef logic [TAG_W-1:0] tag_t;
    typedef logic [LAT_W-1:0] lat_t;

    // Per-operand wakeup state.
    typedef struct packed {
        logic             seen;     // sticky: parent tag observed
        logic             rdy;      // countdown expired, value available
        lat_t             cnt;      // remaining cycles to readiness
        logic [GP_N-1:0]  gp_seen;  // sticky: grandparent tag observed
    } opnd_t;

endpackage

// File: rtl/sgw_operand.sv
module sgw_operand
    import sgw_pkg::*;
#(
    parameter int BC_N = 2
) (
    input  logic                    load,
    input  logic                    ld_vld,
    input  tag_t                    ld_tag,
    input  logic [GP_N-1:0]         ld_gvld,
    input  tag_t [GP_N-1:0]         ld_gtag,
    input  opnd_t                   cur,
    input  tag_t                    cur_tag,
    input  tag_t [GP_N-1:0]         cur_gtag,
    input  logic                    multi,
    input  logic [BC_N-1:0]         bc_valid,
    input  tag_t [BC_N-1:0]         bc_tag,
    input  lat_t [BC_N-1:0]         bc_lat,
    output opnd_t                   nxt,
    output logic                    rdy,
    output logic                    spec
);

    always_comb begin
        opnd_t           base;
        tag_t            ptag;
        tag_t [GP_N-1:0] gtag;
        logic            hit;
        lat_t            hlat;

        if (load) begin
            base.seen    = 1'b0;
            base.rdy     = !ld_vld;
            base.cnt     = '0;
            base.gp_seen = ld_vld ? ~ld_gvld : '1;
            ptag         = ld_tag;
            gtag         = ld_gtag;
        end else begin
            base = cur;
            ptag = cur_tag;
            gtag = cur_gtag;
        end

        hit  = 1'b0;
        hlat = '0;
        for (int k = 0; k < BC_N; k++) begin
            if (!hit && bc_valid[k] && bc_tag[k] == ptag) begin
                hit  = 1'b1;
                hlat = bc_lat[k];
            end
        end

        nxt = base;
        if (!base.rdy) begin
            if (base.seen) begin
                if (base.cnt <= lat_t'(1)) begin
                    nxt.rdy = 1'b1;
                    nxt.cnt = '0;
                end else begin
                    nxt.cnt = base.cnt - lat_t'(1);
                end
            end else if (hit) begin
                nxt.seen    = 1'b1;
                nxt.gp_seen = '1;
                if (hlat <= lat_t'(1)) begin
                    nxt.rdy = 1'b1;
                end else begin
                    nxt.cnt = hlat - lat_t'(1);
                end
            end else begin
                for (int g = 0; g < GP_N; g++) begin
                    for (int k = 0; k < BC_N; k++) begin
                        if (bc_valid[k] && bc_tag[k] == gtag[g]) begin
                            nxt.gp_seen[g] = 1'b1;
                        end
                    end
                end
            end
        end
    end

    assign rdy  = cur.rdy;
    assign spec = cur.rdy | (!multi & (&cur.gp_seen));

endmodule

// File: rtl/sgw_alloc.sv
module sgw_alloc #(
    parameter int N_ENT = 8,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic [N_ENT-1:0] busy,
    output logic             found,
    output logic [IDX_W-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int e = N_ENT - 1; e >= 0; e--) begin
            if (!busy[e]) begin
                found = 1'b1;
                idx   = IDX_W'(e);
            end
        end
    end

endmodule

// File: rtl/sgw_select.sv
module sgw_select #(
    parameter int N_ENT   = 8,
    parameter int ISSUE_W = 2,
    localparam int IDX_W  = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int CNT_W  = $clog2(N_ENT + 1)
) (
    input  logic [N_ENT-1:0]                req,
    input  logic [N_ENT-1:0][N_ENT-1:0]     older,
    output logic [N_ENT-1:0]                gnt,
    output logic [ISSUE_W-1:0]              slot_vld,
    output logic [ISSUE_W-1:0][IDX_W-1:0]   slot_idx
);

    logic [N_ENT-1:0][CNT_W-1:0] rank;

    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            rank[i] = '0;
            for (int j = 0; j < N_ENT; j++) begin
                rank[i] = rank[i] + CNT_W'(req[j] & older[i][j]);
            end
            gnt[i] = req[i] && (rank[i] < CNT_W'(ISSUE_W));
        end
    end

    always_comb begin
        for (int s = 0; s < ISSUE_W; s++) begin
            slot_vld[s] = 1'b0;
            slot_idx[s] = '0;
            for (int i = 0; i < N_ENT; i++) begin
                if (gnt[i] && rank[i] == CNT_W'(s)) begin
                    slot_vld[s] = 1'b1;
                    slot_idx[s] = IDX_W'(i);
                end
            end
        end
    end

endmodule

// File: rtl/sgw_sched.sv
module sgw_sched
    import sgw_pkg::*;
#(
    parameter int N_ENT   = 8,
    parameter int ISSUE_W = 2,
    parameter int SRC_N   = 2,
    parameter int BC_N    = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          disp_valid,
    input  logic [TAG_W-1:0]              disp_dst,
    input  logic [SRC_N-1:0]              disp_src_vld,
    input  logic [SRC_N*TAG_W-1:0]        disp_src_tag,
    input  logic [SRC_N-1:0]              disp_src_multi,
    input  logic [SRC_N*GP_N-1:0]         disp_gp_vld,
    input  logic [SRC_N*GP_N*TAG_W-1:0]   disp_gp_tag,
    input  logic [BC_N-1:0]               bc_valid,
    input  logic [BC_N*TAG_W-1:0]         bc_tag,
    input  logic [BC_N*LAT_W-1:0]         bc_lat,
    output logic                          disp_ready,
    output logic [ISSUE_W-1:0]            iss_valid,
    output logic [ISSUE_W-1:0]            iss_confirm,
    output logic [ISSUE_W*TAG_W-1:0]      iss_tag
);

    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    typedef struct packed {
        logic [N_ENT-1:0]                           vld;
        logic [N_ENT-1:0][N_ENT-1:0]                older;
        tag_t [N_ENT-1:0]                           dst;
        tag_t [N_ENT-1:0][SRC_N-1:0]                stag;
        logic [N_ENT-1:0][SRC_N-1:0]                multi;
        tag_t [N_ENT-1:0][SRC_N-1:0][GP_N-1:0]      gtag;
        opnd_t [N_ENT-1:0][SRC_N-1:0]               op;
        logic [ISSUE_W-1:0]                         iss_vld;
        logic [ISSUE_W-1:0]                         iss_conf;
        tag_t [ISSUE_W-1:0]                         iss_tag;
    } state_t;

    state_t state_q, state_d;

    logic                               ld_en;
    logic                               alloc_found;
    logic [IDX_W-1:0]                   ld_idx;
    logic [N_ENT-1:0]                   ld_sel;
    opnd_t [N_ENT-1:0][SRC_N-1:0]       op_nxt;
    logic [N_ENT-1:0][SRC_N-1:0]        op_rdy;
    logic [N_ENT-1:0][SRC_N-1:0]        op_spec;
    logic [N_ENT-1:0]                   req;
    logic [N_ENT-1:0]                   conf;
    logic [N_ENT-1:0]                   gnt;
    logic [N_ENT-1:0]                   freed;
    logic [ISSUE_W-1:0]                 slot_vld;
    logic [ISSUE_W-1:0][IDX_W-1:0]      slot_idx;

    // Entry allocation
    sgw_alloc #(.N_ENT(N_ENT)) u_alloc (
        .busy  (state_q.vld),
        .found (alloc_found),
        .idx   (ld_idx)
    );

    assign ld_en = disp_valid & alloc_found;

    // Wakeup stage: one tracker per entry operand
    for (genvar e = 0; e < N_ENT; e++) begin : g_ent
        assign ld_sel[e] = ld_en && (ld_idx == IDX_W'(e));
        for (genvar s = 0; s < SRC_N; s++) begin : g_src
            sgw_operand #(.BC_N(BC_N)) u_op (
                .load     (ld_sel[e]),
                .ld_vld   (disp_src_vld[s]),
                .ld_tag   (disp_src_tag[s*TAG_W +: TAG_W]),
                .ld_gvld  (disp_gp_vld[s*GP_N +: GP_N]),
                .ld_gtag  (disp_gp_tag[s*GP_N*TAG_W +: GP_N*TAG_W]),
                .cur      (state_q.op[e][s]),
                .cur_tag  (state_q.stag[e][s]),
                .cur_gtag (state_q.gtag[e][s]),
                .multi    (state_q.multi[e][s]),
                .bc_valid (bc_valid),
                .bc_tag   (bc_tag),
                .bc_lat   (bc_lat),
                .nxt      (op_nxt[e][s]),
                .rdy      (op_rdy[e][s]),
                .spec     (op_spec[e][s])
            );
        end
        assign req[e]   = state_q.vld[e] & (&op_spec[e]);
        assign conf[e]  = state_q.vld[e] & (&op_rdy[e]);
        assign freed[e] = gnt[e] & conf[e];
    end

    // Select stage: oldest-first, up to ISSUE_W grants
    sgw_select #(.N_ENT(N_ENT), .ISSUE_W(ISSUE_W)) u_sel (
        .req      (req),
        .older    (state_q.older),
        .gnt      (gnt),
        .slot_vld (slot_vld),
        .slot_idx (slot_idx)
    );

    always_comb begin
        state_d    = state_q;
        state_d.op = op_nxt;

        for (int s = 0; s < ISSUE_W; s++) begin
            state_d.iss_vld[s]  = slot_vld[s];
            state_d.iss_conf[s] = slot_vld[s] & conf[slot_idx[s]];
            state_d.iss_tag[s]  = slot_vld[s] ? state_q.dst[slot_idx[s]] : '0;
        end

        state_d.vld = state_q.vld & ~freed;

        if (ld_en) begin
            state_d.vld[ld_idx] = 1'b1;
            state_d.dst[ld_idx] = disp_dst;
            for (int s = 0; s < SRC_N; s++) begin
                state_d.stag[ld_idx][s]  = disp_src_tag[s*TAG_W +: TAG_W];
                state_d.multi[ld_idx][s] = disp_src_multi[s];
                for (int g = 0; g < GP_N; g++) begin
                    state_d.gtag[ld_idx][s][g] =
                        disp_gp_tag[(s*GP_N+g)*TAG_W +: TAG_W];
                end
            end
            for (int e = 0; e < N_ENT; e++) begin
                state_d.older[e][ld_idx] = 1'b0;
            end
            for (int e = 0; e < N_ENT; e++) begin
                state_d.older[ld_idx][e] = state_q.vld[e] & ~freed[e];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign disp_ready  = ~&state_q.vld;
    assign iss_valid   = state_q.iss_vld;
    assign iss_confirm = state_q.iss_conf;
    assign iss_tag     = state_q.iss_tag;

endmodule

// File: rtl/sgw_sched_chk.sv
module sgw_sched_chk #(
    parameter int ISSUE_W = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               disp_ready,
    input logic [ISSUE_W-1:0] iss_valid,
    input logic [ISSUE_W-1:0] iss_confirm
);

    // R1: outputs idle on the edge after a reset cycle
    a_r1_idle_after_reset: assert property (@(posedge clk)
        !rst_n |=> (iss_valid == '0));

    // R9: slots fill from slot 0 upward
    a_r9_slots_packed: assert property (@(posedge clk) disable iff (!rst_n)
        ((iss_valid + ISSUE_W'(1)) & iss_valid) == '0);

    // R8: confirm only on a slot that carries a grant
    a_r8_confirm_on_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_confirm & ~iss_valid) == '0);

    // R10: a confirmed issue leaves a free entry behind
    a_r10_confirm_frees: assert property (@(posedge clk) disable iff (!rst_n)
        (|iss_confirm) |-> disp_ready);

endmodule

bind sgw_sched sgw_sched_chk #(.ISSUE_W(ISSUE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .disp_ready  (disp_ready),
    .iss_valid   (iss_valid),
    .iss_confirm (iss_confirm)
);

// File: tb/sgw_sched_bench.sv
`timescale 1ns/1ps
module sgw_sched_bench;

    localparam int TW = 6;
    localparam int LW = 3;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        disp_valid;
    logic [5:0]  disp_dst;
    logic [1:0]  disp_src_vld;
    logic [11:0] disp_src_tag;
    logic [1:0]  disp_src_multi;
    logic [3:0]  disp_gp_vld;
    logic [23:0] disp_gp_tag;
    logic [1:0]  bc_valid;
    logic [11:0] bc_tag;
    logic [5:0]  bc_lat;
    logic        disp_ready;
    logic [1:0]  iss_valid;
    logic [1:0]  iss_confirm;
    logic [11:0] iss_tag;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    sgw_sched u_sgw_sched (
        .clk(clk), .rst_n(rst_n),
        .disp_valid(disp_valid), .disp_dst(disp_dst),
        .disp_src_vld(disp_src_vld), .disp_src_tag(disp_src_tag),
        .disp_src_multi(disp_src_multi), .disp_gp_vld(disp_gp_vld),
        .disp_gp_tag(disp_gp_tag), .bc_valid(bc_valid), .bc_tag(bc_tag),
        .bc_lat(bc_lat), .disp_ready(disp_ready), .iss_valid(iss_valid),
        .iss_confirm(iss_confirm), .iss_tag(iss_tag)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        disp_valid = 0; disp_dst = 0; disp_src_vld = 0; disp_src_tag = 0;
        disp_src_multi = 0; disp_gp_vld = 0; disp_gp_tag = 0;
        bc_valid = 0; bc_tag = 0; bc_lat = 0;
    endtask

    task automatic chk(input string rq, input bit ok, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic exp_slots(input string rq, input bit v0, input bit c0, input int t0,
                             input bit v1, input bit c1, input int t1);
        logic [15:0] a, e;
        a = {iss_valid, iss_confirm,
             iss_valid[1] ? iss_tag[11:6] : 6'd0, iss_valid[0] ? iss_tag[5:0] : 6'd0};
        e = {v1, v0, c1, c0, v1 ? t1[5:0] : 6'd0, v0 ? t0[5:0] : 6'd0};
        chk(rq, a == e, int'(a), int'(e));
    endtask

    task automatic exp_none(input string rq);
        exp_slots(rq, 0, 0, 0, 0, 0, 0);
    endtask

    // Set source s fields for the pending dispatch
    task automatic set_src(input int s, input bit v, input int tag, input bit multi,
                           input bit g0v, input int g0, input bit g1v, input int g1);
        disp_src_vld[s]          = v;
        disp_src_tag[s*TW +: TW] = tag[5:0];
        disp_src_multi[s]        = multi;
        disp_gp_vld[s*2]         = g0v;
        disp_gp_vld[s*2+1]       = g1v;
        disp_gp_tag[(s*2)*TW +: TW]   = g0[5:0];
        disp_gp_tag[(s*2+1)*TW +: TW] = g1[5:0];
    endtask

    task automatic set_bc(input int b, input int tag, input int lat);
        bc_valid[b]          = 1'b1;
        bc_tag[b*TW +: TW]   = tag[5:0];
        bc_lat[b*LW +: LW]   = lat[2:0];
    endtask

    // Dispatch one instruction waiting on source 0 only (multi-cycle parent)
    task automatic disp_wait(input int dst, input int tag);
        disp_valid = 1; disp_dst = dst[5:0];
        set_src(0, 1, tag, 1, 0, 0, 0, 0);
        step();
        clear_in();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not end actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        clear_in();
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        exp_none("R1 slots after reset");
        chk("R1 disp_ready after reset", disp_ready == 1, int'(disp_ready), 1);

        // R2 no pending sources
        disp_valid = 1; disp_dst = 5;
        step(); clear_in();
        exp_none("R2 not yet issued");
        step();
        exp_slots("R2 issue one edge after dispatch", 1, 1, 5, 0, 0, 0);
        step();
        exp_none("R2 issued once");

        // R3 latency sweep, 0 treated as 1
        for (int lat = 0; lat < 8; lat++) begin
            int lp;
            lp = (lat < 1) ? 1 : lat;
            disp_wait(10 + lat, 20);
            step(); step();
            exp_none("R3 waiting before broadcast");
            set_bc(0, 20, lat);
            step(); clear_in();
            exp_none("R3 broadcast edge");
            for (int k = 1; k <= lp; k++) begin
                step();
                if (k < lp) exp_none("R3 countdown running");
                else exp_slots("R3 issue at latency", 1, 1, 10 + lat, 0, 0, 0);
            end
            step();
            exp_none("R3 entry freed");
        end

        // R4 non-matching ignored, sticky match
        disp_wait(30, 21);
        set_bc(0, 22, 1);
        step(); clear_in();
        step(); step(); step();
        exp_none("R4 foreign tag ignored");
        set_bc(1, 21, 3);
        step(); clear_in();
        step(); step();
        exp_none("R4 countdown not done");
        step();
        exp_slots("R4 sticky match issues without rebroadcast", 1, 1, 30, 0, 0, 0);
        step();

        // R5 / R6 grandparent speculation
        disp_valid = 1; disp_dst = 40;
        set_src(0, 1, 23, 0, 1, 24, 1, 25);
        step(); clear_in();
        step();
        exp_none("R5 no request before grandparents");
        set_bc(0, 24, 1);
        step(); clear_in();
        step(); step();
        exp_none("R5 one grandparent is not enough");
        set_bc(0, 25, 1);
        step(); clear_in();
        step();
        exp_slots("R5 speculative select, confirm low", 1, 0, 40, 0, 0, 0);
        step();
        exp_slots("R6 false selection stays and re-requests", 1, 0, 40, 0, 0, 0);
        set_bc(0, 23, 2);
        step(); clear_in();
        exp_slots("R6 still false on parent broadcast edge", 1, 0, 40, 0, 0, 0);
        step();
        exp_slots("R6 still false while counting", 1, 0, 40, 0, 0, 0);
        step();
        exp_slots("R6 confirmed once parent ready", 1, 1, 40, 0, 0, 0);
        step();
        exp_none("R6 freed after confirmed grant");

        // R7 multi-cycle parent excluded
        disp_valid = 1; disp_dst = 50;
        set_src(0, 1, 26, 1, 1, 27, 0, 0);
        step(); clear_in();
        set_bc(0, 27, 1);
        step(); clear_in();
        step(); step(); step();
        exp_none("R7 grandparent ignored for multi-cycle parent");
        set_bc(0, 26, 1);
        step(); clear_in();
        step();
        exp_slots("R7 issue on own tag", 1, 1, 50, 0, 0, 0);
        step();

        // R9 oldest first against entry index
        disp_wait(1, 31);
        disp_wait(2, 31);
        disp_wait(60, 30);
        disp_wait(61, 30);
        disp_wait(62, 30);
        exp_none("R9 all waiting");
        set_bc(0, 31, 1);
        step(); clear_in();
        step();
        exp_slots("R9 two blockers issue", 1, 1, 1, 1, 1, 2);
        disp_wait(63, 30);
        set_bc(0, 30, 1);
        step(); clear_in();
        step();
        exp_slots("R9 oldest pair first", 1, 1, 60, 1, 1, 61);
        step();
        exp_slots("R9 younger pair next, low index last", 1, 1, 62, 1, 1, 63);
        step();
        exp_none("R9 drained");

        // R10 full station
        for (int i = 0; i < 8; i++) disp_wait(48 + i, 9);
        chk("R10 disp_ready low when full", disp_ready == 0, int'(disp_ready), 0);
        disp_wait(63, 9);
        set_bc(0, 9, 1);
        step(); clear_in();
        step();
        exp_slots("R10 drain 0", 1, 1, 48, 1, 1, 49);
        chk("R10 disp_ready after confirmed issue", disp_ready == 1, int'(disp_ready), 1);
        step();
        exp_slots("R10 drain 1", 1, 1, 50, 1, 1, 51);
        step();
        exp_slots("R10 drain 2", 1, 1, 52, 1, 1, 53);
        step();
        exp_slots("R10 drain 3", 1, 1, 54, 1, 1, 55);
        step();
        exp_none("R10 dropped dispatch never issues");

        // R11 broadcast in dispatch cycle
        disp_valid = 1; disp_dst = 56;
        set_src(0, 1, 41, 1, 0, 0, 0, 0);
        set_bc(0, 41, 2);
        step(); clear_in();
        step();
        exp_none("R11 captured broadcast still counting");
        step();
        exp_slots("R11 issue after latency", 1, 1, 56, 0, 0, 0);
        step();

        // R8 two sources, second bus
        disp_valid = 1; disp_dst = 57;
        set_src(0, 1, 42, 1, 0, 0, 0, 0);
        set_src(1, 1, 43, 1, 0, 0, 0, 0);
        step(); clear_in();
        set_bc(0, 42, 1);
        step(); clear_in();
        step(); step(); step();
        exp_none("R8 one of two sources ready");
        set_bc(1, 43, 1);
        step(); clear_in();
        step();
        exp_slots("R8 all sources ready via bus 1", 1, 1, 57, 0, 0, 0);
        step();

        // R8 mixed: speculative source with a ready source gives false selection
        disp_valid = 1; disp_dst = 58;
        set_src(0, 1, 44, 0, 1, 45, 0, 0);
        set_src(1, 1, 46, 1, 0, 0, 0, 0);
        step(); clear_in();
        set_bc(0, 46, 1);
        set_bc(1, 45, 1);
        step(); clear_in();
        step();
        exp_slots("R8 confirm low with speculative source", 1, 0, 58, 0, 0, 0);
        set_bc(0, 44, 1);
        step(); clear_in();
        exp_slots("R8 still false on parent broadcast edge", 1, 0, 58, 0, 0, 0);
        step();
        exp_slots("R8 confirm once both ready", 1, 1, 58, 0, 0, 0);
        step();
        exp_none("R8 freed");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule